// File: doc/BRIEF.md
# Lock-Line Reservation Unit

This unit gives one processing element load-reserve and store-conditional access to 128-byte lines of main memory. A line is handled as sixteen 64-bit doublewords. A reserving read copies a whole line from main memory into local memory. While it does so, it keeps a private snapshot of the line and records which line is reserved. A later conditional store checks that the reservation is still held for the same line. It then walks the line one doubleword at a time. A doubleword that software left unchanged is skipped. A changed doubleword is written to main memory only if memory still holds the snapshot value at that place. The first doubleword that fails this test ends the command with a failure.

Plain stores copy a full line from local memory to main memory. If the line is the reserved one, the reservation is dropped. An external kill input models a write by another agent to the reserved line and also drops the reservation. Every command except the quiet store leaves a result code in a single-entry status slot. A reader polls that slot and pops it. Main and local memory are reached through simple synchronous ports with a one-cycle read latency.

Top module: `llr_unit`

## Requirements
- R1: After reset the unit is idle (`cmd_ready`=1), the status slot is empty, and no reservation is held, so the first conditional store fails.
- R2: A reserving read (`cmd_op`=0) copies all 16 doublewords of main line `cmd_line` into local line `cmd_ls_line` and reserves that line. It posts code 4, which is visible after the 33rd rising edge, counting the accepting edge as the first.
- R3: A conditional store (`cmd_op`=1) posts failure code 1 after the first edge, with no memory access, when no reservation is held or when `cmd_line` differs from the reserved line.
- R4: A conditional store writes a doubleword to main memory only when the local value differs from the snapshot. Each unchanged doubleword costs 2 cycles and each changed doubleword costs 4. Success code 0 is visible after 1 + that sum edges.
- R5: If main memory no longer matches the snapshot at a changed doubleword, the store posts code 1 at that point and stops. Doublewords written before that point remain written, and that doubleword is left unwritten.
- R6: Every accepted conditional store clears the reservation, whether it succeeds or fails.
- R7: A plain store (`cmd_op`=2) or a quiet store (`cmd_op`=3) copies all 16 doublewords of the local line to the main line. It clears the reservation only when `cmd_line` equals the reserved line. Op 2 posts code 2 after 33 edges, and op 3 posts nothing.
- R8: A pulse on `kill` clears the reservation, so a following conditional store fails.
- R9: The status slot holds one code. `stat_valid` stays high until `stat_rd` pops it, a pop of an empty slot has no effect, and a newly posted code replaces an unread one.
- R10: A command presented while `cmd_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is high |
| cmd_op | input | 2 | 0 reserve-read, 1 conditional store, 2 store, 3 quiet store |
| cmd_line | input | MLINE_W | Main-memory line index |
| cmd_ls_line | input | LLINE_W | Local-memory line index |
| cmd_ready | output | 1 | Unit idle |
| kill | input | 1 | External reservation kill |
| mem_rd | output | 1 | Main memory read request |
| mem_we | output | 1 | Main memory write enable |
| mem_addr | output | MLINE_W+4 | Main memory doubleword address |
| mem_wdata | output | DATA_W | Main memory write data |
| mem_rdata | input | DATA_W | Main memory read data, one cycle after mem_rd |
| ls_rd | output | 1 | Local memory read request |
| ls_we | output | 1 | Local memory write enable |
| ls_addr | output | LLINE_W+4 | Local memory doubleword address |
| ls_wdata | output | DATA_W | Local memory write data |
| ls_rdata | input | DATA_W | Local memory read data, one cycle after ls_rd |
| stat_rd | input | 1 | Pop the status slot |
| stat_valid | output | 1 | Status slot holds a code |
| stat_code | output | 3 | Status code |

## Verification
Each status code has a due edge fixed by the command and the line contents. Fast failures are due on the accepting edge. Reserving reads, plain stores and all-unchanged conditional stores are due on the 33rd edge. Other conditional stores are due after 1 plus 2 or 4 cycles per doubleword, up to the point where they stop. The driver works out this edge when it accepts the command and queues it with the code. The monitor compares the arrival cycle as well as the code, so a unit that is early or late by one cycle is reported. Memory contents are compared line by line only once the unit is idle again.

// File: rtl/llr_pkg.sv
package llr_pkg;
  localparam int LINE_DWS = 16;
  localparam int DW_IDX_W = $clog2(LINE_DWS);

  typedef enum logic [1:0] {
    OP_GET  = 2'd0,
    OP_PUTC = 2'd1,
    OP_PUTU = 2'd2,
    OP_PUTQ = 2'd3
  } llr_op_e;

  typedef enum logic [2:0] {
    STS_PUTC_OK   = 3'd0,
    STS_PUTC_FAIL = 3'd1,
    STS_PUTU_OK   = 3'd2,
    STS_GET_OK    = 3'd4
  } llr_sts_e;

  typedef enum logic [3:0] {
    S_IDLE, S_G_RD, S_G_WR, S_C_LRD, S_C_CMP, S_C_MRD, S_C_MCHK, S_U_LRD, S_U_MWR
  } llr_state_e;
endpackage

// File: rtl/llr_snapshot.sv
module llr_snapshot #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // registered read; output holds between reads
  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/llr_resv.sv
module llr_resv #(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic              set,
  input  logic [LINE_W-1:0] set_line,
  input  logic              clr,
  output logic              valid,
  output logic [LINE_W-1:0] line
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      line  <= '0;
    end else if (kill) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
      line  <= set_line;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/llr_stat_slot.sv
module llr_stat_slot #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post,
  input  logic [CODE_W-1:0] post_code,
  input  logic              rd,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      code  <= '0;
    end else if (post) begin
      valid <= 1'b1;
      code  <= post_code;
    end else if (rd) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/llr_unit.sv
module llr_unit
  import llr_pkg::*;
#(
  parameter int MLINE_W = 8,
  parameter int LLINE_W = 6,
  parameter int DATA_W  = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [MLINE_W-1:0]          cmd_line,
  input  logic [LLINE_W-1:0]          cmd_ls_line,
  output logic                        cmd_ready,
  input  logic                        kill,
  output logic                        mem_rd,
  output logic                        mem_we,
  output logic [MLINE_W+DW_IDX_W-1:0] mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic                        ls_rd,
  output logic                        ls_we,
  output logic [LLINE_W+DW_IDX_W-1:0] ls_addr,
  output logic [DATA_W-1:0]           ls_wdata,
  input  logic [DATA_W-1:0]           ls_rdata,
  input  logic                        stat_rd,
  output logic                        stat_valid,
  output logic [2:0]                  stat_code
);
  localparam logic [DW_IDX_W-1:0] LAST_IDX = DW_IDX_W'(LINE_DWS - 1);

  llr_state_e           state;
  logic [DW_IDX_W-1:0]  idx;
  llr_op_e              op_q, op_in;
  logic [MLINE_W-1:0]   line_q;
  logic [LLINE_W-1:0]   ls_line_q;
  logic [DATA_W-1:0]    newv_q, snap_rd;
  logic                 rsv_valid;
  logic [MLINE_W-1:0]   rsv_line;
  logic                 accept, rsv_hit, last, dw_diff, mem_match;
  logic                 post, rsv_set, rsv_clr;
  llr_sts_e             post_code;

  assign op_in     = llr_op_e'(cmd_op);
  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign rsv_hit   = rsv_valid && (rsv_line == cmd_line);
  assign last      = (idx == LAST_IDX);
  assign dw_diff   = (ls_rdata != snap_rd);
  assign mem_match = (mem_rdata == snap_rd);

  // memory port drive, decoded from the state register
  assign mem_rd    = (state == S_G_RD) || (state == S_C_MRD);
  assign mem_we    = (state == S_U_MWR) || (state == S_C_MCHK && mem_match);
  assign mem_addr  = {line_q, idx};
  assign mem_wdata = (state == S_U_MWR) ? ls_rdata : newv_q;
  assign ls_rd     = (state == S_C_LRD) || (state == S_U_LRD);
  assign ls_we     = (state == S_G_WR);
  assign ls_addr   = {ls_line_q, idx};
  assign ls_wdata  = mem_rdata;

  assign rsv_set = (state == S_G_WR) && last;
  assign rsv_clr = accept && ((op_in == OP_PUTC) ||
                   ((op_in == OP_PUTU || op_in == OP_PUTQ) && rsv_line == cmd_line));

  always_comb begin
    post      = 1'b0;
    post_code = STS_PUTC_FAIL;
    case (state)
      S_IDLE:   if (accept && op_in == OP_PUTC && !rsv_hit) post = 1'b1;
      S_G_WR:   if (last) begin post = 1'b1; post_code = STS_GET_OK; end
      S_C_CMP:  if (!dw_diff && last) begin post = 1'b1; post_code = STS_PUTC_OK; end
      S_C_MCHK: begin
        if (!mem_match) post = 1'b1;
        else if (last) begin post = 1'b1; post_code = STS_PUTC_OK; end
      end
      S_U_MWR:  if (last && op_q == OP_PUTU) begin post = 1'b1; post_code = STS_PUTU_OK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      op_q      <= OP_GET;
      line_q    <= '0;
      ls_line_q <= '0;
      newv_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q      <= op_in;
          line_q    <= cmd_line;
          ls_line_q <= cmd_ls_line;
          idx       <= '0;
          case (op_in)
            OP_GET:  state <= S_G_RD;
            OP_PUTC: if (rsv_hit) state <= S_C_LRD;
            default: state <= S_U_LRD;
          endcase
        end
        S_G_RD: state <= S_G_WR;
        S_G_WR: begin
          idx   <= idx + 1'b1;
          state <= last ? S_IDLE : S_G_RD;
        end
        S_C_LRD: state <= S_C_CMP;
        S_C_CMP: begin
          newv_q <= ls_rdata;
          if (dw_diff) state <= S_C_MRD;
          else if (last) state <= S_IDLE;
          else begin idx <= idx + 1'b1; state <= S_C_LRD; end
        end
        S_C_MRD: state <= S_C_MCHK;
        S_C_MCHK: begin
          if (!mem_match || last) state <= S_IDLE;
          else begin idx <= idx + 1'b1; state <= S_C_LRD; end
        end
        S_U_LRD: state <= S_U_MWR;
        S_U_MWR: begin
          idx   <= idx + 1'b1;
          state <= last ? S_IDLE : S_U_LRD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  llr_snapshot #(.DATA_W(DATA_W), .DEPTH(LINE_DWS)) u_snap (
    .clk(clk), .we(state == S_G_WR), .waddr(idx), .wdata(mem_rdata),
    .re(state == S_C_LRD), .raddr(idx), .rdata(snap_rd)
  );

  llr_resv #(.LINE_W(MLINE_W)) u_resv (
    .clk(clk), .rst(rst), .kill(kill), .set(rsv_set), .set_line(line_q),
    .clr(rsv_clr), .valid(rsv_valid), .line(rsv_line)
  );

  llr_stat_slot #(.CODE_W(3)) u_stat (
    .clk(clk), .rst(rst), .post(post), .post_code(post_code), .rd(stat_rd),
    .valid(stat_valid), .code(stat_code)
  );
endmodule

// File: rtl/llr_checker.sv
module llr_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       cmd_ready,
  input logic       kill,
  input logic       stat_rd,
  input logic       stat_valid,
  input logic       mem_we,
  input logic       ls_we,
  input logic       rsv_valid
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_ready && !stat_valid));

  assert_get_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd_valid && cmd_op == 2'd0) |=> !cmd_ready);

  assert_cond_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && cmd_valid && cmd_op == 2'd1) |=> !rsv_valid);

  assert_kill_clears_R8: assert property (@(posedge clk) disable iff (rst)
    kill |=> !rsv_valid);

  assert_slot_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !stat_rd) |=> stat_valid);

  assert_idle_no_post_R9: assert property (@(posedge clk) disable iff (rst)
    (!stat_valid && cmd_ready && !cmd_valid) |=> !stat_valid);

  assert_port_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && ls_we));
endmodule

bind llr_unit llr_checker u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .kill(kill), .stat_rd(stat_rd), .stat_valid(stat_valid),
  .mem_we(mem_we), .ls_we(ls_we), .rsv_valid(rsv_valid)
);

// File: tb/sim_llr_unit.sv
module sim_llr_unit;
  localparam int MLW = 4;
  localparam int LLW = 4;
  localparam int DW  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic           cmd_valid = 1'b0;
  logic [1:0]     cmd_op = 2'd0;
  logic [MLW-1:0] cmd_line = '0;
  logic [LLW-1:0] cmd_ls_line = '0;
  logic           cmd_ready, kill = 1'b0;
  logic           mem_rd, mem_we, ls_rd, ls_we;
  logic [MLW+3:0] mem_addr;
  logic [LLW+3:0] ls_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata, ls_wdata, ls_rdata;
  logic           stat_rd, stat_valid;
  logic [2:0]     stat_code;
  logic           mon_rd = 1'b0, tb_rd = 1'b0, mon_hold = 1'b0;
  assign stat_rd = mon_rd | tb_rd;

  llr_unit #(.MLINE_W(MLW), .LLINE_W(LLW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .cmd_ls_line(cmd_ls_line), .cmd_ready(cmd_ready), .kill(kill),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ls_rd(ls_rd), .ls_we(ls_we), .ls_addr(ls_addr),
    .ls_wdata(ls_wdata), .ls_rdata(ls_rdata), .stat_rd(stat_rd),
    .stat_valid(stat_valid), .stat_code(stat_code)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mem_m [256];
  logic [DW-1:0] ls_m  [256];
  logic [DW-1:0] exp_mem [256];
  logic [DW-1:0] exp_ls  [256];
  logic          bw_en = 1'b0, bw_ls = 1'b0;
  logic [7:0]    bw_addr = '0;
  logic [DW-1:0] bw_data = '0;
  int    q_code[$], q_due[$];
  string q_tag[$];
  int    m_code, m_due;
  string m_tag;

  function automatic logic [DW-1:0] seed_val(int a);
    return 64'hC0DE_0000_0000_0000 | (64'(a) * 64'h0001_0003_0005);
  endfunction

  // bench-owned main and local memories, one-cycle read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) begin
        mem_m[i] <= seed_val(i);
        ls_m[i]  <= '0;
      end
    end else begin
      if (mem_we) mem_m[mem_addr] <= mem_wdata;
      if (ls_we)  ls_m[ls_addr]   <= ls_wdata;
      if (bw_en) begin
        if (bw_ls) ls_m[bw_addr] <= bw_data;
        else       mem_m[bw_addr] <= bw_data;
      end
    end
    if (mem_rd) mem_rdata <= mem_m[mem_addr];
    if (ls_rd)  ls_rdata  <= ls_m[ls_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pops each status and compares code and arrival cycle
  always @(negedge clk) begin
    if (rst || mon_hold) mon_rd = 1'b0;
    else if (stat_valid) begin
      if (q_code.size() == 0) chk(1'b0, "R7 unexpected status", 64'(stat_code), 64'hF);
      else begin
        m_code = q_code.pop_front();
        m_due  = q_due.pop_front();
        m_tag  = q_tag.pop_front();
        chk(int'(stat_code) == m_code, m_tag, 64'(stat_code), 64'(m_code));
        chk(cyc == m_due, {m_tag, " timing"}, 64'(cyc), 64'(m_due));
      end
      mon_rd = 1'b1;
    end else mon_rd = 1'b0;
  end

  task automatic wait_idle();
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (cmd_ready && q_code.size() == 0) return;
    end
    while (q_code.size() != 0) begin
      chk(1'b0, {q_tag[0], " missing"}, 64'd0, 64'(q_code[0]));
      void'(q_code.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
    end
  endtask

  task automatic issue(input logic [1:0] op, input int ml, input int ll, input bit sts,
                       input int code, input int n, input string tag, input bit wt = 1'b1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_line = ml[MLW-1:0]; cmd_ls_line = ll[LLW-1:0];
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (sts) begin
      q_code.push_back(code); q_due.push_back(cyc + n - 1); q_tag.push_back(tag);
    end
    if (wt) wait_idle();
  endtask

  task automatic exp_get(input int ml, input int ll);
    for (int k = 0; k < 16; k++) exp_ls[ll*16+k] = exp_mem[ml*16+k];
  endtask

  task automatic exp_put(input int ml, input int ll);
    for (int k = 0; k < 16; k++) exp_mem[ml*16+k] = exp_ls[ll*16+k];
  endtask

  task automatic do_get(input int ml, input int ll, input bit sts = 1'b1);
    exp_get(ml, ll);
    issue(2'd0, ml, ll, sts, 4, 33, "R2 reserve status");
  endtask

  task automatic bwrite(input bit is_ls, input int line, input int dw, input logic [DW-1:0] v);
    @(negedge clk);
    bw_en = 1'b1; bw_ls = is_ls; bw_addr = 8'(line*16+dw); bw_data = v;
    if (is_ls) exp_ls[line*16+dw] = v; else exp_mem[line*16+dw] = v;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic chk_mline(input int ml, input string tag);
    int bad = -1;
    for (int k = 0; k < 16; k++)
      if (bad < 0 && mem_m[ml*16+k] !== exp_mem[ml*16+k]) bad = k;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, mem_m[ml*16+bad], exp_mem[ml*16+bad]);
  endtask

  task automatic chk_lline(input int ll, input string tag);
    int bad = -1;
    for (int k = 0; k < 16; k++)
      if (bad < 0 && ls_m[ll*16+k] !== exp_ls[ll*16+k]) bad = k;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, ls_m[ll*16+bad], exp_ls[ll*16+bad]);
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin exp_mem[i] = seed_val(i); exp_ls[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 idle after reset", 64'(cmd_ready), 1);
    chk(stat_valid == 1'b0, "R1 slot empty after reset", 64'(stat_valid), 0);
    issue(2'd1, 0, 0, 1, 1, 1, "R1 no reservation after reset");

    // reserve, busy command ignored meanwhile
    exp_get(3, 5);
    issue(2'd0, 3, 5, 1, 4, 33, "R2 reserve status", 1'b0);
    repeat (6) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_line = 4'd11; cmd_ls_line = 4'd0;
    @(negedge clk) cmd_valid = 1'b0;
    wait_idle();
    chk_lline(5, "R2 line copied to local");
    chk_mline(11, "R10 busy command ignored");

    // conditional store, two changed doublewords
    bwrite(1, 5, 2, 64'h1111);
    bwrite(1, 5, 9, 64'h2222);
    issue(2'd1, 3, 5, 1, 0, 1 + 14*2 + 2*4, "R4 conditional success");
    exp_put(3, 5);
    chk_mline(3, "R4 changed words written");
    issue(2'd1, 3, 5, 1, 1, 1, "R6 reservation cleared by store");
    chk_mline(3, "R6 failed store leaves memory");

    // another agent changes the line under the reservation
    do_get(3, 5);
    bwrite(0, 3, 7, 64'hBAD0);
    bwrite(1, 5, 1, 64'h3333);
    bwrite(1, 5, 7, 64'h4444);
    issue(2'd1, 3, 5, 1, 1, 1 + 2 + 4 + 10 + 4, "R5 snapshot mismatch fails");
    exp_mem[3*16+1] = 64'h3333;
    chk_mline(3, "R5 partial write kept");

    do_get(4, 2);
    issue(2'd1, 6, 2, 1, 1, 1, "R3 address mismatch fails");
    chk_mline(6, "R3 no write on mismatch");

    do_get(4, 2);
    @(negedge clk) kill = 1'b1;
    @(negedge clk) kill = 1'b0;
    issue(2'd1, 4, 2, 1, 1, 1, "R8 kill drops reservation");

    do_get(4, 2);
    bwrite(1, 2, 0, 64'h5555);
    issue(2'd2, 4, 2, 1, 2, 33, "R7 plain store status");
    exp_put(4, 2);
    chk_mline(4, "R7 plain store writes line");
    issue(2'd1, 4, 2, 1, 1, 1, "R7 matching store clears");

    do_get(4, 2);
    issue(2'd3, 8, 2, 0, 0, 0, "R7 quiet store");
    exp_put(8, 2);
    chk_mline(8, "R7 quiet store writes line");
    issue(2'd1, 4, 2, 1, 0, 33, "R7 other line keeps reservation");

    do_get(5, 3);
    issue(2'd3, 5, 3, 0, 0, 0, "R7 quiet store same line");
    issue(2'd1, 5, 3, 1, 1, 1, "R7 quiet store clears");

    // single-entry slot: hold, overwrite, pop, pop empty
    @(negedge clk) mon_hold = 1'b1;
    do_get(1, 7, 1'b0);
    chk(stat_valid == 1'b1, "R9 code held until read", 64'(stat_valid), 1);
    chk(stat_code == 3'd4, "R9 held code", 64'(stat_code), 4);
    issue(2'd2, 9, 7, 0, 0, 0, "R9 overwrite");
    exp_put(9, 7);
    chk(stat_code == 3'd2 && stat_valid, "R9 newer code replaces", 64'(stat_code), 2);
    @(negedge clk) tb_rd = 1'b1;
    @(negedge clk) tb_rd = 1'b0;
    chk(stat_valid == 1'b0, "R9 pop empties slot", 64'(stat_valid), 0);
    @(negedge clk) tb_rd = 1'b1;
    @(negedge clk) tb_rd = 1'b0;
    chk(stat_valid == 1'b0, "R9 pop of empty slot", 64'(stat_valid), 0);
    mon_hold = 1'b0;
    issue(2'd1, 1, 7, 1, 0, 33, "R9 status after empty pop");
    chk_mline(9, "R7 store line 9");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule